// File: doc/BRIEF.md
# Seven-Stage Pipeline Interlock and Forwarding Controller

This block decides, every cycle, whether an in-order integer pipeline with seven stages (two fetch stages, decode, execute, a first memory stage that also retires ALU results, a second memory stage, and a load retire stage) may advance. It looks at the register sources of the instruction in decode and at the destination and kind of the instructions in execute and in the two memory stages. From these it raises a front-end stall, requests a bubble into execute, flushes the fetch and decode stages on a taken branch, and produces the operand bypass selects for execute.

ALU results retire in the first memory stage. Load data exists only at the end of the second memory stage. Because of this, a load consumed by the very next instruction costs two stall cycles, and with one independent instruction in between it costs one. The bypass selects are computed while the consumer is still in decode and are registered. They are therefore steady from the start of the consumer's execute cycle and need no late comparator in front of the operand muxes. All pins are plain control signals. There is no streaming interface, so no valid/ready back-pressure applies.

Top module: `pipe7_hazard_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fwd_sel_o` is all zeros.
- R2: Stage kinds are encoded 0 = ALU, 1 = load, 2 = store, 3 = branch. A valid load in execute whose destination equals a nonzero decode source raises `stall_o` and `bubble_o` in that same cycle. A dependent instruction directly behind a load therefore stalls for two cycles.
- R3: A valid load in the first memory stage whose destination equals a nonzero decode source raises `stall_o` and `bubble_o`, which is one stall cycle for a load-use distance of two.
- R4: A valid load in the second memory stage matching a decode source does not stall. In the next cycle that operand's select is 3, the load-data latch after the second memory stage.
- R5: A valid ALU producer matching a decode source never stalls. One cycle later, the operand's select is 1 (execute/memory-1 latch) when the producer was in execute, and 2 (memory-1/memory-2 latch) when it was in the first memory stage. Operand k uses `id_srcs_i[5k+4:5k]` and `fwd_sel_o[2k+1:2k]`.
- R6: When several stages write the same register, only the youngest one is used, in the order execute, then memory 1, then memory 2. A younger ALU match hides an older load, so no stall occurs.
- R7: Register 0, stores, branches and stages whose valid bit is low never create a dependency. They cause neither a stall nor a nonzero select.
- R8: A valid branch in execute with `ex_taken_i` high raises `flush_o` and `bubble_o` and forces `stall_o` low in the same cycle. A branch that is not taken does not flush.
- R9: After any cycle with a stall, a flush, or decode invalid, both selects are 0 in the next cycle, because a bubble enters execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds a live instruction |
| id_srcs_i | input | NUM_SRC*REG_W | Decode source register numbers, operand 0 in the low bits |
| ex_valid_i | input | 1 | Execute stage holds a live instruction |
| ex_kind_i | input | 2 | Execute instruction kind |
| ex_dst_i | input | REG_W | Execute destination register |
| ex_taken_i | input | 1 | Branch in execute resolved taken |
| m1_valid_i | input | 1 | First memory stage holds a live instruction |
| m1_kind_i | input | 2 | First memory stage kind |
| m1_dst_i | input | REG_W | First memory stage destination |
| m2_valid_i | input | 1 | Second memory stage holds a live instruction |
| m2_kind_i | input | 2 | Second memory stage kind |
| m2_dst_i | input | REG_W | Second memory stage destination |
| stall_o | output | 1 | Freeze both fetch stages and decode |
| bubble_o | output | 1 | Execute receives no instruction next cycle |
| flush_o | output | 1 | Squash both fetch stages and decode |
| fwd_sel_o | output | 2*NUM_SRC | Registered bypass select per execute operand |

## Verification
The hardest situations to reach are the ones where several in-flight producers name the same register and their kinds disagree. Examples are a load sitting behind a younger ALU write, and a taken branch arriving in the same cycle as a load-use hazard. A real pipeline reaches these only through specific instruction orderings. The bench therefore drives the stage contents directly, first in directed cycles that recreate each ordering and then with random contents drawn from a pool of only four register numbers, so that matches across stages are frequent. A behavioural model, written as a nearest-producer search, predicts every output in every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    FW_RF   = 2'd0,
    FW_EXM1 = 2'd1,
    FW_M1M2 = 2'd2,
    FW_LOAD = 2'd3
  } fwd_e;

  // producers visible from decode: execute, memory 1, memory 2 (youngest first)
  localparam int N_PROD = 3;
  localparam int SEL_W  = 2;

  function automatic logic writes_reg(input logic vld, input kind_e k);
    return vld && (k == K_ALU || k == K_LOAD);
  endfunction

  // bypass point for an ALU producer that is 'age' stages ahead of decode
  function automatic fwd_e alu_path(input int age);
    case (age)
      0:       return FW_EXM1;
      1:       return FW_M1M2;
      default: return FW_RF;
    endcase
  endfunction
endpackage

// File: rtl/hz_src_scan.sv
module hz_src_scan
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]        src_i,
  input  logic [N_PROD-1:0]       prod_wr_i,
  input  logic [N_PROD-1:0]       prod_ld_i,
  input  logic [N_PROD*REG_W-1:0] prod_dst_i,
  output logic                    haz_o,
  output fwd_e                    sel_o
);
  logic hit;

  // walk from the youngest producer; the first match decides
  always_comb begin
    haz_o = 1'b0;
    sel_o = FW_RF;
    hit   = 1'b0;
    for (int i = 0; i < N_PROD; i++) begin
      if (!hit && (src_i != '0) && prod_wr_i[i] &&
          (prod_dst_i[i*REG_W +: REG_W] == src_i)) begin
        hit = 1'b1;
        if (prod_ld_i[i]) begin
          if (i == N_PROD - 1) sel_o = FW_LOAD;
          else                 haz_o = 1'b1;
        end else begin
          sel_o = alu_path(i);
        end
      end
    end
  end
endmodule

// File: rtl/hz_stall_arb.sv
module hz_stall_arb
  import hz_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               id_valid_i,
  input  logic [NUM_SRC-1:0] haz_i,
  input  logic               ex_valid_i,
  input  kind_e              ex_kind_i,
  input  logic               ex_taken_i,
  output logic               stall_o,
  output logic               bubble_o,
  output logic               flush_o,
  output logic               clr_sel_o
);
  always_comb begin
    flush_o   = ex_valid_i && (ex_kind_i == K_BRANCH) && ex_taken_i;
    // a squashed decode instruction has no hazard to wait for
    stall_o   = id_valid_i && (|haz_i) && !flush_o;
    bubble_o  = stall_o || flush_o;
    clr_sel_o = bubble_o || !id_valid_i;
  end
endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/pipe7_hazard_ctrl.sv
module pipe7_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     id_valid_i,
  input  logic [NUM_SRC*REG_W-1:0] id_srcs_i,
  input  logic                     ex_valid_i,
  input  logic [1:0]               ex_kind_i,
  input  logic [REG_W-1:0]         ex_dst_i,
  input  logic                     ex_taken_i,
  input  logic                     m1_valid_i,
  input  logic [1:0]               m1_kind_i,
  input  logic [REG_W-1:0]         m1_dst_i,
  input  logic                     m2_valid_i,
  input  logic [1:0]               m2_kind_i,
  input  logic [REG_W-1:0]         m2_dst_i,
  output logic                     stall_o,
  output logic                     bubble_o,
  output logic                     flush_o,
  output logic [NUM_SRC*SEL_W-1:0] fwd_sel_o
);
  localparam int SELS_W = NUM_SRC * SEL_W;

  kind_e ex_k, m1_k, m2_k;
  logic [N_PROD-1:0]       prod_wr, prod_ld;
  logic [N_PROD*REG_W-1:0] prod_dst;
  logic [NUM_SRC-1:0]      haz;
  logic [SELS_W-1:0]       sel_next;
  logic                    clr_sel;

  assign ex_k = kind_e'(ex_kind_i);
  assign m1_k = kind_e'(m1_kind_i);
  assign m2_k = kind_e'(m2_kind_i);

  // index 0 = execute (youngest), 2 = memory 2 (oldest)
  assign prod_wr  = {writes_reg(m2_valid_i, m2_k), writes_reg(m1_valid_i, m1_k),
                     writes_reg(ex_valid_i, ex_k)};
  assign prod_ld  = {m2_k == K_LOAD, m1_k == K_LOAD, ex_k == K_LOAD};
  assign prod_dst = {m2_dst_i, m1_dst_i, ex_dst_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_e sel_g;
    hz_src_scan #(.REG_W(REG_W)) scan_i (
      .src_i      (id_srcs_i[g*REG_W +: REG_W]),
      .prod_wr_i  (prod_wr),
      .prod_ld_i  (prod_ld),
      .prod_dst_i (prod_dst),
      .haz_o      (haz[g]),
      .sel_o      (sel_g)
    );
    assign sel_next[g*SEL_W +: SEL_W] = sel_g;
  end

  hz_stall_arb #(.NUM_SRC(NUM_SRC)) arb_i (
    .id_valid_i (id_valid_i),
    .haz_i      (haz),
    .ex_valid_i (ex_valid_i),
    .ex_kind_i  (ex_k),
    .ex_taken_i (ex_taken_i),
    .stall_o    (stall_o),
    .bubble_o   (bubble_o),
    .flush_o    (flush_o),
    .clr_sel_o  (clr_sel)
  );

  hz_fwd_reg #(.W(SELS_W)) sel_reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_sel),
    .d_i   (sel_next),
    .q_o   (fwd_sel_o)
  );
endmodule

// File: rtl/pipe7_hazard_ctrl_chk.sv
module pipe7_hazard_ctrl_chk #(
  parameter int NUM_SRC = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   id_valid_i,
  input logic                   ex_valid_i,
  input logic [1:0]             ex_kind_i,
  input logic                   ex_taken_i,
  input logic                   m1_valid_i,
  input logic [1:0]             m1_kind_i,
  input logic                   m2_valid_i,
  input logic [1:0]             m2_kind_i,
  input logic                   stall_o,
  input logic                   bubble_o,
  input logic                   flush_o,
  input logic [2*NUM_SRC-1:0]   fwd_sel_o
);
  // R8
  flush_beats_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (!stall_o && bubble_o));

  // R8
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (ex_valid_i && ex_kind_i == 2'd3 && ex_taken_i));

  // R2
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> bubble_o);

  // R3
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> ((ex_valid_i && ex_kind_i == 2'd1) || (m1_valid_i && m1_kind_i == 2'd1)));

  // R9
  bubble_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o || flush_o || !id_valid_i) |=> (fwd_sel_o == '0));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    // R4
    load_path_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_sel_o[2*g +: 2] == 2'd3) |-> $past(m2_valid_i && m2_kind_i == 2'd1));
    // R5
    exm1_path_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_sel_o[2*g +: 2] == 2'd1) |-> $past(ex_valid_i && ex_kind_i == 2'd0));
    // R5
    m1m2_path_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_sel_o[2*g +: 2] == 2'd2) |-> $past(m1_valid_i && m1_kind_i == 2'd0));
  end
endmodule

bind pipe7_hazard_ctrl pipe7_hazard_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid_i (id_valid_i),
  .ex_valid_i (ex_valid_i),
  .ex_kind_i  (ex_kind_i),
  .ex_taken_i (ex_taken_i),
  .m1_valid_i (m1_valid_i),
  .m1_kind_i  (m1_kind_i),
  .m2_valid_i (m2_valid_i),
  .m2_kind_i  (m2_kind_i),
  .stall_o    (stall_o),
  .bubble_o   (bubble_o),
  .flush_o    (flush_o),
  .fwd_sel_o  (fwd_sel_o)
);

// File: tb/pipe7_hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
module pipe7_hazard_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       id_v = 1'b0;
  logic [4:0] sa = '0, sb = '0;
  logic       pv [3];
  logic [1:0] pk [3];
  logic [4:0] pd [3];
  logic       tk = 1'b0;

  logic       stall, bubble, flush;
  logic [3:0] fwd;

  logic [3:0] exp_fwd = '0;
  string      exp_tag = "R1";

  pipe7_hazard_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid_i(id_v), .id_srcs_i({sb, sa}),
    .ex_valid_i(pv[0]), .ex_kind_i(pk[0]), .ex_dst_i(pd[0]), .ex_taken_i(tk),
    .m1_valid_i(pv[1]), .m1_kind_i(pk[1]), .m1_dst_i(pd[1]),
    .m2_valid_i(pv[2]), .m2_kind_i(pk[2]), .m2_dst_i(pd[2]),
    .stall_o(stall), .bubble_o(bubble), .flush_o(flush), .fwd_sel_o(fwd)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // nearest writer of s: {needs_wait, path code}
  function automatic logic [2:0] ref_scan(logic [4:0] s);
    int nearest = -1;
    if (s == 0) return 3'b000;
    for (int a = 2; a >= 0; a--)
      if (pv[a] && pk[a] <= 2'd1 && pd[a] == s) nearest = a;
    if (nearest < 0) return 3'b000;
    if (pk[nearest] == 2'd1) return (nearest == 2) ? 3'b011 : 3'b100;
    if (nearest == 0) return 3'b001;
    if (nearest == 1) return 3'b010;
    return 3'b000;
  endfunction

  task automatic cyc(string tag, logic iv, logic [4:0] a, logic [4:0] b,
                     logic v0, logic [1:0] k0, logic [4:0] d0, logic t,
                     logic v1, logic [1:0] k1, logic [4:0] d1,
                     logic v2, logic [1:0] k2, logic [4:0] d2);
    logic [2:0] ra, rb;
    logic e_fl, e_st, e_bu;
    @(negedge clk);
    chk(exp_tag, "fwd_sel", int'(fwd), int'(exp_fwd));
    id_v = iv; sa = a; sb = b; tk = t;
    pv[0] = v0; pk[0] = k0; pd[0] = d0;
    pv[1] = v1; pk[1] = k1; pd[1] = d1;
    pv[2] = v2; pk[2] = k2; pd[2] = d2;
    #1;
    ra = ref_scan(a);
    rb = ref_scan(b);
    e_fl = v0 && k0 == 2'd3 && t;
    e_st = iv && (ra[2] || rb[2]) && !e_fl;
    e_bu = e_st || e_fl;
    chk(tag, "stall", int'(stall), int'(e_st));
    chk(tag, "bubble", int'(bubble), int'(e_bu));
    chk(tag, "flush", int'(flush), int'(e_fl));
    exp_fwd = (e_bu || !iv) ? 4'd0 : {rb[1:0], ra[1:0]};
    exp_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pk[i] = '0; pd[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "fwd_sel in reset", int'(fwd), 0);
    rst_n = 1'b1;
    // idle first cycle after reset
    cyc("R1", 0, 0, 0,  0,0,0,0, 0,0,0, 0,0,0);
    // R5: ALU in EX, then ALU in MEM1
    cyc("R5", 1, 7, 0,  1,0,7,0, 0,0,0, 0,0,0);
    cyc("R5", 1, 0, 9,  0,0,0,0, 1,0,9, 0,0,0);
    // R2: load directly ahead, two stall cycles, then load path
    cyc("R2", 1, 5, 0,  1,1,5,0, 0,0,0, 0,0,0);
    cyc("R2", 1, 5, 0,  0,0,0,0, 1,1,5, 0,0,0);
    cyc("R4", 1, 5, 0,  0,0,0,0, 0,0,0, 1,1,5);
    cyc("R4", 1, 0, 0,  1,0,5,0, 0,0,0, 0,0,0);
    // R3: one instruction between
    cyc("R3", 1, 0, 4,  1,0,8,0, 1,1,4, 0,0,0);
    cyc("R4", 1, 0, 4,  0,0,0,0, 0,0,0, 1,1,4);
    // R6: younger ALU hides older load
    cyc("R6", 1, 6, 6,  1,0,6,0, 1,1,6, 0,0,0);
    cyc("R6", 1, 6, 0,  0,0,0,0, 1,0,6, 1,1,6);
    cyc("R6", 1, 3, 3,  1,0,3,0, 1,0,3, 1,0,3);
    // R7: r0, store, branch, invalid stages
    cyc("R7", 1, 0, 0,  1,1,0,0, 1,1,0, 1,1,0);
    cyc("R7", 1, 3, 2,  1,2,3,0, 1,3,2, 0,1,3);
    cyc("R7", 1, 3, 3,  0,1,3,0, 0,0,3, 0,1,3);
    // R8: taken branch with load-use hazard; untaken branch
    cyc("R8", 1, 2, 0,  1,3,0,1, 1,1,2, 0,0,0);
    cyc("R9", 1, 0, 0,  1,3,0,0, 0,0,0, 0,0,0);
    // R9: decode invalid despite match
    cyc("R9", 0, 7, 7,  1,0,7,0, 0,0,0, 0,0,0);
    cyc("R9", 1, 0, 0,  0,0,0,0, 0,0,0, 0,0,0);
    // random stage contents with a small register pool
    for (int n = 0; n < 400; n++) begin
      cyc("R6", 1'($urandom_range(0, 3) != 0),
          5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
          1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
    end
    cyc("R9", 0, 0, 0,  0,0,0,0, 0,0,0, 0,0,0);
    @(negedge clk);
    chk(exp_tag, "fwd_sel", int'(fwd), int'(exp_fwd));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule